// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the slave-side serial engine of a small SPI flash device. It runs on a fast system clock and samples the chip select, serial clock, serial data and hold pins as ordinary synchronous inputs. It turns the serial bit stream into opcode, address and dummy bytes, decodes them, and streams data back on a tri-state serial output for array reads, status reads and the two identification reads. Array data comes from a synchronous read port on the storage model. The status byte comes from an input. Write-type commands are not executed here. Each one is reported as a single-cycle strobe with an operation code, a 19-bit address and a data byte, and only when chip select returns high on a clean byte boundary. Page-program data bytes are passed on one at a time as they arrive.

The block also handles the power-down command and its wake-up, and the hold pin. During hold, the serial clock and serial data are ignored and the output floats. The SPI mode (clock idle low or idle high) needs no setting: the edge detector is loaded with the clock level at select, so both modes decode the same way. The serial clock half period must be at least three system clocks.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset, so_oe, mem_rd_en, cmd_valid and pgm_valid are all 0, and the block is not in power-down, so an identification read works at once.
- R2: Commands decode and data streams identically whether SCK idles low (mode 0) or high (mode 3) when chip select falls.
- R3: SI is sampled on rising SCK, MSB first. SO changes only on falling SCK, MSB first. so_oe is 0 during opcode, address and dummy bytes and while deselected.
- R4: Opcode 03h takes three address bytes, of which the low 19 bits are used. The byte at that address is output starting on the first falling SCK after the last address bit.
- R5: Opcode 0Bh takes three address bytes plus one ignored dummy byte before data starts.
- R6: During an array read the address steps by one per byte and wraps from 7FFFFh to 00000h.
- R7: Opcode 05h outputs status_in, re-sampled at the start of every byte, for as long as the clock runs.
- R8: Opcode 9Fh outputs 62h, 1Eh, 62h, … alternating for as long as the clock runs.
- R9: Opcode ABh takes two dummy bytes and an address byte. Output starts with 62h when bit 0 of that byte is 0, or with 1Eh when it is 1, and then alternates.
- R10: On the chip-select rise, cmd_valid pulses only if a whole number of bytes was received, with this cmd_op encoding:
  - 06h, 1 byte → 1
  - 04h, 1 byte → 2
  - D7h, 4 bytes → 3
  - D8h, 4 bytes → 4
  - C7h, 1 byte → 5
  - 02h, at least 5 bytes → 6
  - 01h, exactly 2 bytes → 7 (cmd_data = the second byte)

  cmd_addr carries the low 19 address bits. Each 02h data byte raises pgm_valid with pgm_data.
- R11: A status-write (01h) transaction that carries two or more data bytes raises no strobe.
- R12: After B9h, every opcode except ABh is ignored: there is no output and no strobe. Receiving the ABh opcode byte leaves power-down. A B9h that ends while wr_busy is 1 is ignored.
- R13: Hold starts when HOLD# falls while SCK is low and ends when HOLD# rises. During hold, so_oe is 0 and SCK and SI edges are ignored, so a stream resumes exactly where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Hold, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for so |
| mem_rd_en | output | 1 | Read request to storage |
| mem_rd_addr | output | ADDR_W | Read address |
| mem_rd_data | input | 8 | Read data, valid the clock after mem_rd_en, held until the next request |
| status_in | input | 8 | Status byte to report |
| wr_busy | input | 1 | Internal write in progress |
| cmd_valid | output | 1 | One-cycle write-type command strobe |
| cmd_op | output | 3 | Operation code (R10) |
| cmd_addr | output | ADDR_W | Command address |
| cmd_data | output | 8 | Status-write data byte |
| pgm_valid | output | 1 | Page-program data byte strobe |
| pgm_data | output | 8 | Page-program data byte |

## Verification
A pin change is registered on the next system clock edge and acted on at the edge after it. An output bit therefore appears two clocks after the SCK fall that causes it. A command strobe appears two clocks after chip select rises. An array read request issues three clocks after the last address bit's rising edge, and its data is ready one clock later, well before the following fall. The bench holds every SCK level for four clocks and samples SO at the end of each low phase, just before the next rise. It reads strobe records only after chip select has been high for eight clocks, so every result is already settled when it is checked.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_WREN        = 3'd1,
    OP_WRDIS       = 3'd2,
    OP_ERASE_SMALL = 3'd3,
    OP_ERASE_BLOCK = 3'd4,
    OP_ERASE_ALL   = 3'd5,
    OP_PROGRAM     = 3'd6,
    OP_STATUS_WR   = 3'd7
  } wr_op_e;

  typedef enum logic [1:0] {
    SRC_NONE, SRC_ARRAY, SRC_STATUS, SRC_ID
  } out_src_e;

  localparam logic [7:0] CMD_READ     = 8'h03;
  localparam logic [7:0] CMD_FASTREAD = 8'h0B;
  localparam logic [7:0] CMD_STAT_RD  = 8'h05;
  localparam logic [7:0] CMD_STAT_WR  = 8'h01;
  localparam logic [7:0] CMD_WR_EN    = 8'h06;
  localparam logic [7:0] CMD_WR_DIS   = 8'h04;
  localparam logic [7:0] CMD_ER_SMALL = 8'hD7;
  localparam logic [7:0] CMD_ER_BLOCK = 8'hD8;
  localparam logic [7:0] CMD_ER_ALL   = 8'hC7;
  localparam logic [7:0] CMD_PROGRAM  = 8'h02;
  localparam logic [7:0] CMD_SLEEP    = 8'hB9;
  localparam logic [7:0] CMD_ID_WAKE  = 8'hAB;
  localparam logic [7:0] CMD_ID_SHORT = 8'h9F;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_q,
  output logic si_q,
  output logic hold_q,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic cs_p, sck_q, sck_p, hin_q, hin_p, live;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q <= 1'b1; cs_p <= 1'b1;
      sck_q <= 1'b0; sck_p <= 1'b0;
      si_q <= 1'b0;
      hin_q <= 1'b1; hin_p <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      cs_q  <= cs_n;   cs_p  <= cs_q;
      sck_q <= sck;    sck_p <= sck_q;
      si_q  <= si;
      hin_q <= hold_n; hin_p <= hin_q;
      if (cs_q)                         hold_q <= 1'b0;
      else if (hin_p && !hin_q && !sck_q) hold_q <= 1'b1;
      else if (!hin_p && hin_q)           hold_q <= 1'b0;
    end
  end

  // Edge detector tracks SCK even while masked, so the idle level at select
  // (mode 0 or mode 3) never produces a spurious edge.
  assign live     = !cs_q && !hold_q;
  assign sck_rise = live && sck_q && !sck_p;
  assign sck_fall = live && !sck_q && sck_p;
  assign cs_rise  = cs_q && !cs_p;
endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rise,
  input  logic             si,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx,
  output logic [CNT_W-1:0] byte_count,
  output logic             on_boundary
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [2:0] bit_cnt;
  logic [6:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bit_cnt    <= 3'd0;
      byte_count <= '0;
      byte_done  <= 1'b0;
      byte_idx   <= '0;
      byte_val   <= 8'd0;
      sh         <= 7'd0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        sh      <= {sh[5:0], si};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          byte_val  <= {sh, si};
          byte_idx  <= byte_count;
          if (byte_count != CNT_MAX) byte_count <= byte_count + CNT_W'(1);
        end
      end
    end
  end

  assign on_boundary = (bit_cnt == 3'd0);

  a_r3_byte_on_rise: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> $past(rise));
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       fall,
  input  logic       enable,
  input  logic [7:0] src_byte,
  output logic       so,
  output logic       oe,
  output logic       byte_end
);
  logic [2:0] bit_cnt;
  logic [6:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      bit_cnt  <= 3'd0;
      sh       <= 7'd0;
      so       <= 1'b0;
      oe       <= 1'b0;
      byte_end <= 1'b0;
    end else begin
      byte_end <= 1'b0;
      if (fall && enable) begin
        oe <= 1'b1;
        if (bit_cnt == 3'd0) begin
          so <= src_byte[7];
          sh <= src_byte[6:0];
        end else begin
          so <= sh[6];
          sh <= {sh[5:0], 1'b0};
        end
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) byte_end <= 1'b1;
      end
    end
  end

  a_r3_so_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!fall && !clear) |=> $stable(so));
  a_r3_byte_end_after_fall: assert property (@(posedge clk) disable iff (rst)
    byte_end |-> $past(fall));
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
  parameter int          ADDR_W   = 19,
  parameter logic [7:0]  MFR_CODE = 8'h62,
  parameter logic [7:0]  DEV_CODE = 8'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic [7:0]        status_in,
  input  logic              wr_busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              pgm_valid,
  output logic [7:0]        pgm_data
);
  import spi_fe_pkg::*;

  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] IDX_OP   = CNT_W'(0);
  localparam logic [CNT_W-1:0] IDX_A1   = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_A3   = CNT_W'(3);
  localparam logic [CNT_W-1:0] IDX_DUM  = CNT_W'(4);

  logic cs_q, si_q, hold_q, sck_rise, sck_fall, cs_rise;
  logic byte_done, on_boundary;
  logic [7:0] byte_val;
  logic [CNT_W-1:0] byte_idx, byte_count;
  logic tx_oe, tx_byte_end;
  logic [7:0] src_byte;

  logic [7:0]        opcode_q, sr_byte_q;
  logic              pd_q, id_sel_q;
  out_src_e          src_q;
  logic [ADDR_W-1:0] addr_q, addr_next;
  wr_op_e            wr_op, cmd_op_q;
  logic              accept, sleep_req;

  spi_fe_sync u_sync (
    .clk, .rst, .cs_n, .sck, .si, .hold_n,
    .cs_q, .si_q, .hold_q, .sck_rise, .sck_fall, .cs_rise
  );

  spi_fe_rx #(.CNT_W(CNT_W)) u_rx (
    .clk, .rst, .clear(cs_q), .rise(sck_rise), .si(si_q),
    .byte_done, .byte_val, .byte_idx, .byte_count, .on_boundary
  );

  always_comb begin
    unique case (src_q)
      SRC_ARRAY:  src_byte = mem_rd_data;
      SRC_STATUS: src_byte = status_in;
      SRC_ID:     src_byte = id_sel_q ? DEV_CODE : MFR_CODE;
      default:    src_byte = 8'h00;
    endcase
  end

  spi_fe_tx u_tx (
    .clk, .rst, .clear(cs_q), .fall(sck_fall), .enable(src_q != SRC_NONE),
    .src_byte, .so, .oe(tx_oe), .byte_end(tx_byte_end)
  );

  assign so_oe     = tx_oe && !hold_q;
  assign accept    = !pd_q || (byte_val == CMD_ID_WAKE);
  assign addr_next = {addr_q[ADDR_W-9:0], byte_val};

  // Decode of write-type commands at chip-select rise: whole bytes only.
  always_comb begin
    wr_op = OP_NONE;
    if (on_boundary && !pd_q) begin
      unique case (opcode_q)
        CMD_WR_EN:    if (byte_count == CNT_W'(1)) wr_op = OP_WREN;
        CMD_WR_DIS:   if (byte_count == CNT_W'(1)) wr_op = OP_WRDIS;
        CMD_ER_ALL:   if (byte_count == CNT_W'(1)) wr_op = OP_ERASE_ALL;
        CMD_ER_SMALL: if (byte_count == CNT_W'(4)) wr_op = OP_ERASE_SMALL;
        CMD_ER_BLOCK: if (byte_count == CNT_W'(4)) wr_op = OP_ERASE_BLOCK;
        CMD_PROGRAM:  if (byte_count >= CNT_W'(5)) wr_op = OP_PROGRAM;
        CMD_STAT_WR:  if (byte_count == CNT_W'(2)) wr_op = OP_STATUS_WR;
        default:      wr_op = OP_NONE;
      endcase
    end
  end

  assign sleep_req = on_boundary && !pd_q && !wr_busy &&
                     (opcode_q == CMD_SLEEP) && (byte_count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_q <= 8'h00; sr_byte_q <= 8'h00;
      pd_q <= 1'b0; id_sel_q <= 1'b0; src_q <= SRC_NONE;
      addr_q <= '0; mem_rd_addr <= '0; mem_rd_en <= 1'b0;
      cmd_valid <= 1'b0; cmd_op_q <= OP_NONE; cmd_addr <= '0; cmd_data <= 8'h00;
      pgm_valid <= 1'b0; pgm_data <= 8'h00;
    end else begin
      mem_rd_en <= 1'b0;
      cmd_valid <= 1'b0;
      pgm_valid <= 1'b0;
      if (cs_q) src_q <= SRC_NONE;

      if (byte_done) begin
        if (byte_idx == IDX_OP) begin
          opcode_q <= accept ? byte_val : 8'h00;
          if (pd_q && byte_val == CMD_ID_WAKE) pd_q <= 1'b0;
          if (accept && byte_val == CMD_ID_SHORT) begin
            src_q <= SRC_ID; id_sel_q <= 1'b0;
          end
          if (accept && byte_val == CMD_STAT_RD) src_q <= SRC_STATUS;
        end else begin
          if (byte_idx <= IDX_A3) addr_q <= addr_next;
          if (byte_idx == IDX_A1 && opcode_q == CMD_STAT_WR) sr_byte_q <= byte_val;
          if (byte_idx == IDX_A3 && opcode_q == CMD_READ) begin
            mem_rd_en <= 1'b1; mem_rd_addr <= addr_next; src_q <= SRC_ARRAY;
          end
          if (byte_idx == IDX_DUM && opcode_q == CMD_FASTREAD) begin
            mem_rd_en <= 1'b1; mem_rd_addr <= addr_q; src_q <= SRC_ARRAY;
          end
          if (byte_idx == IDX_A3 && opcode_q == CMD_ID_WAKE) begin
            src_q <= SRC_ID; id_sel_q <= byte_val[0];
          end
          if (byte_idx >= IDX_DUM && opcode_q == CMD_PROGRAM) begin
            pgm_valid <= 1'b1; pgm_data <= byte_val;
          end
        end
      end

      if (tx_byte_end) begin
        id_sel_q <= !id_sel_q;
        if (src_q == SRC_ARRAY) begin
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= mem_rd_addr + ADDR_W'(1);
        end
      end

      if (cs_rise) begin
        cmd_valid <= (wr_op != OP_NONE);
        cmd_op_q  <= wr_op;
        cmd_addr  <= addr_q;
        cmd_data  <= sr_byte_q;
        if (sleep_req) pd_q <= 1'b1;
      end
    end
  end

  assign cmd_op = cmd_op_q;

  a_r3_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    (cs_q && $past(cs_q)) |-> !so_oe);
  a_r10_strobe_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(cs_rise));
  a_r12_no_strobe_asleep: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !$past(pd_q));
  a_r13_hold_freezes_input: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !cs_q) |=> $stable(byte_count));
endmodule

// File: tb/spi_flash_frontend_bench.sv
module spi_flash_frontend_bench;
  localparam int AW = 19;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wr_busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic so, so_oe, mem_rd_en, cmd_valid, pgm_valid;
  logic [AW-1:0] mem_rd_addr, cmd_addr;
  logic [7:0] mem_rd_data, cmd_data, pgm_data;
  logic [2:0] cmd_op;

  int n_tests = 0, n_fail = 0, n_cmd = 0, n_pgm = 0;
  logic [2:0] last_op;
  logic [AW-1:0] last_addr;
  logic [7:0] last_data, last_pgm;
  logic m3 = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_flash_frontend u_spi_flash_frontend (
    .clk, .rst, .cs_n, .sck, .si, .hold_n, .so, .so_oe,
    .mem_rd_en, .mem_rd_addr, .mem_rd_data, .status_in, .wr_busy,
    .cmd_valid, .cmd_op, .cmd_addr, .cmd_data, .pgm_valid, .pgm_data
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[18:16], a[12:8]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rst) mem_rd_data <= 8'h00;
    else if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);
  end

  always @(posedge clk) begin
    if (!rst && cmd_valid) begin
      n_cmd <= n_cmd + 1; last_op <= cmd_op; last_addr <= cmd_addr; last_data <= cmd_data;
    end
    if (!rst && pgm_valid) begin
      n_pgm <= n_pgm + 1; last_pgm <= pgm_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic sel(input logic mode3);
    @(negedge clk); m3 = mode3; sck = mode3;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] b, input int n, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      if (sck) sck = 1'b0;
      si = b[i];
      repeat (HALF) @(negedge clk);
      r[i] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xb(input logic [7:0] b, output logic [7:0] r);
    bits(b, 8, r);
  endtask

  task automatic desel();
    if (!m3) begin sck = 1'b0; repeat (HALF) @(negedge clk); end
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 so_oe after reset", so_oe, 0);
    check("R1 mem_rd_en after reset", mem_rd_en, 0);
    check("R1 cmd_valid after reset", cmd_valid | pgm_valid, 0);
  endtask

  task automatic t_read_plain();
    logic [7:0] r;
    sel(1'b0);
    xb(8'h03, r); xb(8'h01, r); xb(8'h23, r);
    check("R3 no drive during address", so_oe, 0);
    xb(8'h45, r);
    xb(8'hFF, r); check("R4 first byte", r, pat(19'h12345));
    check("R3 drive during data", so_oe, 1);
    xb(8'h00, r); check("R6 increment", r, pat(19'h12346));
    xb(8'h00, r); check("R6 increment 2", r, pat(19'h12347));
    desel();
    check("R3 released after deselect", so_oe, 0);
  endtask

  task automatic t_read_fast_wrap();
    logic [7:0] r;
    sel(1'b1);
    xb(8'h0B, r); xb(8'hF7, r); xb(8'hFF, r); xb(8'hFE, r);
    xb(8'hA5, r);
    check("R5 dummy byte not output", so_oe, 0);
    xb(8'h00, r); check("R5 R2 first byte mode3", r, pat(19'h7FFFE));
    xb(8'h00, r); check("R6 top address", r, pat(19'h7FFFF));
    xb(8'h00, r); check("R6 wrap to zero", r, pat(19'h00000));
    desel();
  endtask

  task automatic t_status();
    logic [7:0] r;
    status_in = 8'hA5;
    sel(1'b1);
    xb(8'h05, r);
    xb(8'h00, r); check("R7 status byte", r, 8'hA5);
    xb(8'h00, r); check("R7 status repeat", r, 8'hA5);
    status_in = 8'h3C;
    xb(8'h00, r); check("R7 status resampled", r, 8'h3C);
    desel();
  endtask

  task automatic t_id_short();
    logic [7:0] r;
    sel(1'b0);
    xb(8'h9F, r);
    xb(8'h00, r); check("R8 first code", r, 8'h62);
    xb(8'h00, r); check("R8 second code", r, 8'h1E);
    xb(8'h00, r); check("R8 alternates", r, 8'h62);
    desel();
  endtask

  task automatic t_id_wake();
    logic [7:0] r;
    sel(1'b1);
    xb(8'hAB, r); xb(8'h00, r); xb(8'h00, r); xb(8'h01, r);
    xb(8'h00, r); check("R9 a0=1 starts device", r, 8'h1E);
    xb(8'h00, r); check("R9 a0=1 alternates", r, 8'h62);
    desel();
    sel(1'b0);
    xb(8'hAB, r); xb(8'hFF, r); xb(8'hFF, r); xb(8'hFE, r);
    xb(8'h00, r); check("R9 a0=0 starts maker", r, 8'h62);
    xb(8'h00, r); check("R9 a0=0 alternates", r, 8'h1E);
    desel();
  endtask

  task automatic run_cmd(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3, input int nbytes, input int extra_bits);
    logic [7:0] r;
    logic [7:0] seq [4];
    seq[0] = b0; seq[1] = b1; seq[2] = b2; seq[3] = b3;
    sel(1'b0);
    for (int k = 0; k < nbytes; k++) xb(seq[k], r);
    if (extra_bits > 0) bits(8'hFF, extra_bits, r);
    desel();
  endtask

  task automatic t_strobes();
    int c;
    logic [7:0] r;
    c = n_cmd; run_cmd(8'h06, 0, 0, 0, 1, 0);
    check("R10 write enable strobe", n_cmd - c, 1); check("R10 op wren", last_op, 1);
    c = n_cmd; run_cmd(8'h04, 0, 0, 0, 1, 0);
    check("R10 op wrdis", last_op, 2);
    c = n_cmd; run_cmd(8'hD7, 8'hF1, 8'h23, 8'h45, 4, 0);
    check("R10 small erase op", last_op, 3); check("R10 small erase addr", last_addr, 19'h12345);
    run_cmd(8'hD8, 8'h02, 8'h05, 8'h00, 4, 0);
    check("R10 block erase op", last_op, 4); check("R10 block erase addr", last_addr, 19'h20500);
    run_cmd(8'hC7, 0, 0, 0, 1, 0);
    check("R10 chip erase op", last_op, 5);
    c = n_cmd; run_cmd(8'h01, 8'hA5, 0, 0, 2, 0);
    check("R10 status write strobe", n_cmd - c, 1);
    check("R10 status write op", last_op, 7); check("R10 status write data", last_data, 8'hA5);
    c = n_cmd; run_cmd(8'h06, 0, 0, 0, 1, 3);
    check("R10 off-boundary ignored", n_cmd - c, 0);
    c = n_cmd; run_cmd(8'hD7, 8'h00, 8'h10, 0, 3, 0);
    check("R10 short erase ignored", n_cmd - c, 0);
    c = n_cmd; run_cmd(8'h02, 8'h01, 8'h00, 8'h10, 4, 0);
    check("R10 program without data ignored", n_cmd - c, 0);
    c = n_cmd; run_cmd(8'h01, 8'hA5, 8'h5A, 0, 3, 0);
    check("R11 long status write ignored", n_cmd - c, 0);
    c = n_cmd;
    begin
      int p;
      p = n_pgm;
      sel(1'b1);
      xb(8'h02, r); xb(8'h01, r); xb(8'h00, r); xb(8'h10, r); xb(8'hAA, r); xb(8'hBB, r);
      desel();
      check("R10 program data bytes", n_pgm - p, 2); check("R10 program last byte", last_pgm, 8'hBB);
    end
    check("R10 program strobe", n_cmd - c, 1);
    check("R10 program op", last_op, 6); check("R10 program addr", last_addr, 19'h10010);
  endtask

  task automatic t_power_down();
    int c;
    logic [7:0] r;
    run_cmd(8'hB9, 0, 0, 0, 1, 0);
    sel(1'b0);
    xb(8'h9F, r); xb(8'h00, r);
    check("R12 id read ignored asleep", so_oe, 0);
    desel();
    c = n_cmd; run_cmd(8'h06, 0, 0, 0, 1, 0);
    check("R12 strobe blocked asleep", n_cmd - c, 0);
    sel(1'b0);
    xb(8'hAB, r); xb(8'h00, r); xb(8'h00, r); xb(8'h00, r);
    xb(8'h00, r); check("R12 wake read id", r, 8'h62);
    desel();
    c = n_cmd; run_cmd(8'h06, 0, 0, 0, 1, 0);
    check("R12 awake again", n_cmd - c, 1);
    wr_busy = 1'b1;
    run_cmd(8'hB9, 0, 0, 0, 1, 0);
    wr_busy = 1'b0;
    c = n_cmd; run_cmd(8'h06, 0, 0, 0, 1, 0);
    check("R12 sleep ignored while busy", n_cmd - c, 1);
  endtask

  task automatic t_hold();
    logic [7:0] r;
    sel(1'b0);
    xb(8'h03, r); xb(8'h00, r); xb(8'h01, r); xb(8'h00, r);
    xb(8'h00, r); check("R13 before hold", r, pat(19'h00100));
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    hold_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check("R13 output floats in hold", so_oe, 0);
    for (int k = 0; k < 3; k++) begin
      si = k[0]; sck = 1'b1; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R13 output back after hold", so_oe, 1);
    xb(8'h00, r); check("R13 stream resumes", r, pat(19'h00101));
    xb(8'h00, r); check("R13 stream continues", r, pat(19'h00102));
    desel();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_id_short();
    t_read_plain();
    t_read_fast_wrap();
    t_status();
    t_id_wake();
    t_strobes();
    t_power_down();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule